// File: doc/BRIEF.md
# Scheduled Periodic Pin Toggler

This block drives one timing output with a square wave of 50 % duty cycle that is locked in phase to the free-running hardware time counter. Software writes two values: an absolute start time in counter ticks (64 bits) and a half-period in ticks (32 bits), which is the spacing between two consecutive pin edges. The half-period sets the output frequency. With a tick of 8 ns, the frequency is one second divided by twice the half-period times 8 ns.

A one-cycle arm strobe captures both values. The strobe is accepted only if the start time lies strictly in the future and the half-period is not zero. Once accepted, the pin inverts when the counter reaches the start time. Every later edge is scheduled at the previous scheduled edge time plus the half-period. Scheduling from the previous edge, and not from the moment an edge is seen, keeps the phase fixed even when the counter is stepped. A one-cycle halt strobe stops toggling, and the pin keeps its level. A later accepted arm strobe restarts the wave from that held level.

Top module: `sched_pin_toggler`

## Requirements
- R1: While reset is asserted, and after it is released with no arm strobe, the pin is 0 and does not toggle.
- R2: An arm strobe with start time strictly greater than the current time and a non-zero half-period arms the block. The pin first inverts in the cycle after the first clock edge at which the sampled time is greater than or equal to the start time.
- R3: While armed, each following edge is due when the sampled time is greater than or equal to the previous scheduled edge time plus the captured half-period. With the time advancing by one per cycle, edges are exactly half-period cycles apart.
- R4: An arm strobe whose start time is less than or equal to the current time is ignored. A stopped pin keeps its level, and a running wave keeps its schedule.
- R5: An arm strobe with a half-period of 0 is ignored in the same way.
- R6: A halt strobe stops toggling from the next cycle on, and the pin holds the level it had.
- R7: After a halt, an accepted arm strobe restarts toggling from the held level, with the first edge at the new start time.
- R8: If the time input jumps past one or more scheduled edges, the pin inverts once per cycle until the schedule has caught up. No edge is lost.
- R9: When halt and arm arrive in the same cycle, halt wins and the block is stopped afterwards.
- R10: The start-time and half-period inputs are captured only by an accepted arm strobe. Changing them at any other time has no effect on the wave.
- R11: An accepted arm strobe while running replaces the schedule without changing the pin level in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_time | input | TIME_W | Current value of the hardware time counter, in ticks |
| start_time | input | TIME_W | Absolute time of the first edge, in ticks |
| half_period | input | PER_W | Ticks between consecutive edges |
| arm | input | 1 | One-cycle strobe that requests a start |
| halt | input | 1 | One-cycle strobe that stops toggling |
| pin | output | 1 | Registered pin level |

## Verification
All decisions are made at a clock edge from the inputs sampled there. The pin is a register, so an edge that is due at clock edge k shows on the pin just after edge k. An arm or halt strobe sampled at edge k changes the run state from edge k onward, so a due edge can first be acted on at edge k+1. The bench drives every input and the time counter at the falling edge. At the next falling edge it compares the pin against a reference model that has been advanced by exactly one sampling edge, so each result is checked in the one cycle in which it is due.

// File: rtl/ptog_pkg.sv
package ptog_pkg;
   typedef enum logic {
      RUN_IDLE = 1'b0,
      RUN_ACTIVE = 1'b1
   } run_e;
endpackage

// File: rtl/ptog_ge_cmp.sv
// Unsigned a >= b. SPLIT selects a two-half structure that shortens the carry chain.
module ptog_ge_cmp #(
   parameter int W     = 64,
   parameter bit SPLIT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         ge
);
   localparam int LO_W = W / 2;
   localparam int HI_W = W - LO_W;

   initial begin
      if (W < 2) $error("ptog_ge_cmp: W must be at least 2");
   end

   generate
      if (SPLIT) begin : g_split
         logic hi_gt, hi_eq, lo_ge;
         always_comb begin
            hi_gt = a[W-1:LO_W] > b[W-1:LO_W];
            hi_eq = a[W-1:LO_W] == b[W-1:LO_W];
            lo_ge = a[LO_W-1:0] >= b[LO_W-1:0];
            ge    = hi_gt | (hi_eq & lo_ge);
         end
      end else begin : g_flat
         always_comb ge = (a >= b);
      end
   endgenerate
endmodule

// File: rtl/ptog_arm_gate.sv
// Decides whether an arm strobe is accepted this cycle.
module ptog_arm_gate #(
   parameter int TIME_W = 64,
   parameter int PER_W  = 32,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [TIME_W-1:0] now_time,
   input  logic [TIME_W-1:0] start_time,
   input  logic [PER_W-1:0]  half_period,
   input  logic              arm,
   input  logic              halt,
   output logic              load
);
   logic now_ge_start;

   ptog_ge_cmp #(.W(TIME_W), .SPLIT(SPLIT)) u_cmp (
      .a  (now_time),
      .b  (start_time),
      .ge (now_ge_start)
   );

   always_comb load = arm & ~halt & ~now_ge_start & (|half_period);
endmodule

// File: rtl/ptog_edge_sched.sv
// Holds run state, next edge time and captured half-period.
module ptog_edge_sched
   import ptog_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int PER_W  = 32,
   parameter bit SPLIT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_time,
   input  logic [TIME_W-1:0] start_time,
   input  logic [PER_W-1:0]  half_period,
   input  logic              load,
   input  logic              halt,
   output logic              toggle,
   output logic              run_o,
   output logic [TIME_W-1:0] edge_o,
   output logic [PER_W-1:0]  per_o
);
   localparam int PAD_W = TIME_W - PER_W;

   run_e              run_q;
   logic [TIME_W-1:0] edge_q;
   logic [PER_W-1:0]  per_q;
   logic              now_ge_edge;

   ptog_ge_cmp #(.W(TIME_W), .SPLIT(SPLIT)) u_cmp (
      .a  (now_time),
      .b  (edge_q),
      .ge (now_ge_edge)
   );

   always_comb toggle = (run_q == RUN_ACTIVE) & now_ge_edge & ~halt & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= RUN_IDLE;
         edge_q <= '0;
         per_q  <= '0;
      end else if (halt) begin
         run_q <= RUN_IDLE;
      end else if (load) begin
         run_q  <= RUN_ACTIVE;
         edge_q <= start_time;
         per_q  <= half_period;
      end else if (toggle) begin
         edge_q <= edge_q + {{PAD_W{1'b0}}, per_q};
      end
   end

   always_comb begin
      run_o  = (run_q == RUN_ACTIVE);
      edge_o = edge_q;
      per_o  = per_q;
   end
endmodule

// File: rtl/ptog_pin_drive.sv
// Registered pin; inverts on each toggle request.
module ptog_pin_drive #(
   parameter bit RESET_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   output logic pin
);
   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pin_q <= RESET_LEVEL;
      else if (toggle) pin_q <= ~pin_q;
   end

   always_comb pin = pin_q;
endmodule

// File: rtl/sched_pin_toggler.sv
module sched_pin_toggler #(
   parameter int TIME_W    = 64,
   parameter int PER_W     = 32,
   parameter bit SPLIT_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_time,
   input  logic [TIME_W-1:0] start_time,
   input  logic [PER_W-1:0]  half_period,
   input  logic              arm,
   input  logic              halt,
   output logic              pin
);
   initial begin
      if (PER_W < 2)       $error("sched_pin_toggler: PER_W must be at least 2");
      if (TIME_W <= PER_W) $error("sched_pin_toggler: TIME_W must exceed PER_W");
   end

   logic              load;
   logic              toggle;
   logic              run_q;
   logic [TIME_W-1:0] edge_q;
   logic [PER_W-1:0]  per_q;

   ptog_arm_gate #(.TIME_W(TIME_W), .PER_W(PER_W), .SPLIT(SPLIT_CMP)) u_gate (
      .now_time    (now_time),
      .start_time  (start_time),
      .half_period (half_period),
      .arm         (arm),
      .halt        (halt),
      .load        (load)
   );

   ptog_edge_sched #(.TIME_W(TIME_W), .PER_W(PER_W), .SPLIT(SPLIT_CMP)) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .now_time    (now_time),
      .start_time  (start_time),
      .half_period (half_period),
      .load        (load),
      .halt        (halt),
      .toggle      (toggle),
      .run_o       (run_q),
      .edge_o      (edge_q),
      .per_o       (per_q)
   );

   ptog_pin_drive #(.RESET_LEVEL(1'b0)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle (toggle),
      .pin    (pin)
   );
endmodule

// File: rtl/ptog_chk.sv
module ptog_chk #(
   parameter int TIME_W = 64,
   parameter int PER_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TIME_W-1:0] now_time,
   input logic [TIME_W-1:0] start_time,
   input logic [PER_W-1:0]  half_period,
   input logic              arm,
   input logic              halt,
   input logic              pin,
   input logic              run_q,
   input logic [TIME_W-1:0] edge_q,
   input logic [PER_W-1:0]  per_q
);
   localparam int PAD_W = TIME_W - PER_W;

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q) |=> $stable(pin)); // R6

   AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !run_q); // R9

   AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !run_q && half_period == '0) |=> !run_q); // R5

   AST_PAST_START: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !run_q && start_time <= now_time) |=> !run_q); // R4

   AST_GOOD_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !halt && half_period != '0 && start_time > now_time)
      |=> (run_q && edge_q == $past(start_time) && $stable(pin))); // R2

   AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !arm && !halt && now_time >= edge_q)
      |=> (pin != $past(pin) &&
           edge_q == $past(edge_q) + {{PAD_W{1'b0}}, $past(per_q)})); // R3

   AST_NOT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !arm && now_time < edge_q) |=> $stable(pin)); // R8
endmodule

bind sched_pin_toggler ptog_chk #(.TIME_W(TIME_W), .PER_W(PER_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .now_time    (now_time),
   .start_time  (start_time),
   .half_period (half_period),
   .arm         (arm),
   .halt        (halt),
   .pin         (pin),
   .run_q       (run_q),
   .edge_q      (edge_q),
   .per_q       (per_q)
);

// File: tb/tb_sched_pin_toggler.sv
module tb_sched_pin_toggler;
   localparam int TIME_W = 64;
   localparam int PER_W  = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [TIME_W-1:0] now_time = 64'd100;
   logic [TIME_W-1:0] start_time = '0;
   logic [PER_W-1:0]  half_period = '0;
   logic              arm = 1'b0;
   logic              halt = 1'b0;
   logic              pin;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string phase = "R1";

   // reference state, derived from the requirements
   bit                m_run = 1'b0;
   bit                m_pin = 1'b0;
   logic [TIME_W-1:0] m_edge = '0;
   logic [PER_W-1:0]  m_per = '0;

   always #4 clk = ~clk;

   sched_pin_toggler #(.TIME_W(TIME_W), .PER_W(PER_W)) dut (
      .clk (clk), .rst_n (rst_n), .now_time (now_time), .start_time (start_time),
      .half_period (half_period), .arm (arm), .halt (halt), .pin (pin)
   );

   function automatic bit accept(input bit a, input bit h, input logic [TIME_W-1:0] st,
                                 input logic [PER_W-1:0] hp, input logic [TIME_W-1:0] nw);
      return a && !h && hp != '0 && st > nw;
   endfunction

   task automatic model_step();
      if (halt) m_run = 1'b0;
      else if (accept(arm, halt, start_time, half_period, now_time)) begin
         m_run = 1'b1; m_edge = start_time; m_per = half_period;
      end else if (m_run && now_time >= m_edge) begin
         m_pin = ~m_pin;
         m_edge = m_edge + {32'd0, m_per};
      end
   endtask

   task automatic check_pin();
      checks++;
      if (pin !== m_pin) begin
         errors++;
         $display("FAIL %s: pin actual %b expected %b at time %0d", phase, pin, m_pin, now_time);
      end
   endtask

   // one cycle: check result of the previous edge, then drive inputs for the next edge
   task automatic cyc(input bit a, input bit h, input logic [TIME_W-1:0] st,
                      input logic [PER_W-1:0] hp, input logic [TIME_W-1:0] step);
      @(negedge clk);
      check_pin();
      arm = a; halt = h;
      start_time = st; half_period = hp;
      now_time = now_time + step;
      model_step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, {$urandom, $urandom}, $urandom, 64'd1);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (pin !== 1'b0) begin
         errors++; $display("FAIL R1: pin in reset actual %b expected 0", pin);
      end
      rst_n = 1'b1;
      idle(5);

      // R2: first edge at start time, then R3 spacing
      phase = "R2";
      cyc(1'b1, 1'b0, now_time + 64'd7, 32'd4, 64'd1);
      idle(12);
      phase = "R3";
      idle(20);
      // R10: inputs change without arm (idle drives random values)
      phase = "R10";
      idle(20);
      // R6: halt, pin holds
      phase = "R6";
      cyc(1'b0, 1'b1, 64'd0, 32'd0, 64'd1);
      idle(15);
      // R4: start equal to now and in the past
      phase = "R4";
      cyc(1'b1, 1'b0, now_time + 64'd1, 32'd3, 64'd1);
      idle(10);
      cyc(1'b1, 1'b0, now_time - 64'd3, 32'd3, 64'd1);
      idle(10);
      // R5: zero half-period
      phase = "R5";
      cyc(1'b1, 1'b0, now_time + 64'd5, 32'd0, 64'd1);
      idle(12);
      // R7: restart from held level
      phase = "R7";
      cyc(1'b1, 1'b0, now_time + 64'd4, 32'd2, 64'd1);
      idle(15);
      // R8: time jumps past several edges
      phase = "R8";
      cyc(1'b0, 1'b0, 64'd0, 32'd0, 64'd11);
      idle(10);
      cyc(1'b0, 1'b0, 64'd0, 32'd0, 64'd0);
      idle(6);
      // R11: re-arm while running
      phase = "R11";
      cyc(1'b1, 1'b0, now_time + 64'd9, 32'd5, 64'd1);
      idle(30);
      // R9: halt and arm together
      phase = "R9";
      cyc(1'b1, 1'b1, now_time + 64'd5, 32'd2, 64'd1);
      idle(12);
      cyc(1'b1, 1'b0, now_time + 64'd3, 32'd1, 64'd1);
      idle(6);
      cyc(1'b1, 1'b1, now_time + 64'd5, 32'd2, 64'd1);
      idle(12);

      // random mix, all requirements
      phase = "R2/R3/R4/R5/R6/R8 random";
      for (int i = 0; i < 4000; i++) begin
         bit a, h;
         logic [TIME_W-1:0] st, stp;
         logic [PER_W-1:0]  hp;
         a   = ($urandom % 25) == 0;
         h   = ($urandom % 70) == 0;
         st  = now_time + 64'($urandom % 40) - 64'd6;
         hp  = $urandom % 8;
         stp = (($urandom % 30) == 0) ? 64'($urandom % 25) : 64'd1;
         cyc(a, h, st, hp, stp);
      end
      idle(2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule